// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block sits in a memory controller between the incoming request stream and the per-bank command slots. Requests carry a bank index, a row address and a read/write flag. Reads and writes are kept in two separate pools, each with its own capacity. In each cycle the block may hand at most one request to one bank whose command slot is free. With each hand-off it reports whether the chosen request targets the row that is already open in that bank (a row hit), or whether an activate will be needed first.

Within a bank, requests to the open row go first. When none match, the oldest request for the bank goes. Once a row has been chosen for a bank, it stays latched for that bank until no queued request to that row remains. A write-drain mode with hysteresis picks which pool is served. The block enters write mode when the number of pending writes reaches a high watermark, and returns to read mode when that number drops below a low watermark. Banks are scanned from a rotating priority pointer that steps by one position after every hand-off.

Top module: `srq_sched`

## Requirements
- R1: After reset both pools are empty. No bank receives a request, and `req_ready` is high for either request type.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. `req_write`=1 selects the write pool and 0 selects the read pool. `req_ready` is low exactly when the selected pool already holds its capacity (RD_DEPTH or WR_DEPTH) at the start of the cycle. While `req_ready` is low, the request is not stored.
- R3: If no row is latched for a bank in the served pool, and some queued request for that bank targets the bank's open row (`bank_open_row[b*ROW_W +: ROW_W]`), the oldest such request is dispatched with `disp_hit`=1, ahead of any older request to another row.
- R4: If no row is latched for a bank and no queued request for it matches its open row, the bank's oldest request is dispatched with `disp_hit`=0, and its row becomes the latched row.
- R5: While a row is latched for a bank, only requests to that row are dispatched to that bank, oldest first, with `disp_hit`=1, whatever the open row is. The latch clears when the last queued request to that row is dispatched.
- R6: The block enters write mode in a cycle when it is in read mode and the pending write count at the start of that cycle is at least WR_HI. It returns to read mode when it is in write mode and that count is below WR_LO. In read mode only reads are dispatched, and in write mode only writes are dispatched (`disp_write` shows the pool).
- R7: At most one bit of `disp_valid` is set per cycle (bit b means bank b). A bank whose `bank_busy` bit is set never receives a request.
- R8: Banks are considered in order starting at the priority pointer (reset value 0) and wrapping around. The first free bank with a pickable request in the served pool is dispatched. After every dispatch the pointer advances by exactly one, modulo NUM_BANKS, regardless of which bank was served.
- R9: When a request is accepted and another is dispatched in the same cycle, both take effect. Pool occupancy afterwards equals the old occupancy plus accepts minus dispatches, and a request accepted in that cycle is appended after all older ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A new request is offered |
| req_ready | output | 1 | The target pool has room this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_bank | input | BANK_W | Target bank of the offered request |
| req_row | input | ROW_W | Target row of the offered request |
| bank_busy | input | NUM_BANKS | Bit b set: bank b's command slot is occupied |
| bank_open_row | input | NUM_BANKS*ROW_W | Currently open row of each bank, bank b in slice b |
| disp_valid | output | NUM_BANKS | One-hot bank receiving a request this cycle |
| disp_row | output | ROW_W | Row of the dispatched request |
| disp_write | output | 1 | Dispatched request came from the write pool |
| disp_hit | output | 1 | Dispatched request is a row hit |

## Verification
The assertions assume the following about the inputs. Reset is held low for the first clock edges. `req_valid` stays low while reset is active. `req_bank` never names a bank at or above NUM_BANKS. The pending write count they track changes only through accepted writes and dispatched writes. The stimulus draws every bank index from the legal range and keeps requests idle during reset. All inputs change only at the falling clock edge, so the combinational ready and dispatch outputs are stable when they are sampled. Because `bank_busy` and `bank_open_row` may take any value, the bench drives them freely, including all-busy stretches that fill both pools to capacity.

// File: rtl/srq_pkg.sv
package srq_pkg;
    typedef enum logic {
        MODE_RD = 1'b0,
        MODE_WR = 1'b1
    } srq_mode_e;
endpackage

// File: rtl/srq_pool.sv
// Request pool kept in arrival order: slot 0 is the oldest entry.
// A removal closes the gap by shifting younger entries down one slot.
module srq_pool #(
    parameter int DEPTH  = 8,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 3,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              push,
    input  logic [BANK_W-1:0]                 push_bank,
    input  logic [ROW_W-1:0]                  push_row,
    input  logic                              pop,
    input  logic [IDX_W-1:0]                  pop_idx,
    output logic [DEPTH-1:0]                  ent_vld,
    output logic [DEPTH-1:0][BANK_W-1:0]      ent_bank,
    output logic [DEPTH-1:0][ROW_W-1:0]       ent_row,
    output logic [CNT_W-1:0]                  count
);
    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][BANK_W-1:0] bank;
        logic [DEPTH-1:0][ROW_W-1:0]  row;
        logic [CNT_W-1:0]             cnt;
    } pool_t;

    pool_t s_d, s_q;

    always_comb begin
        logic [CNT_W-1:0] slot;
        s_d  = s_q;
        slot = s_q.cnt;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= pop_idx) begin
                    s_d.vld[i]  = s_q.vld[i+1];
                    s_d.bank[i] = s_q.bank[i+1];
                    s_d.row[i]  = s_q.row[i+1];
                end
            end
            s_d.vld[DEPTH-1] = 1'b0;
            s_d.cnt          = s_q.cnt - CNT_W'(1);
            slot             = s_q.cnt - CNT_W'(1);
        end
        if (push) begin
            s_d.vld[slot[IDX_W-1:0]]  = 1'b1;
            s_d.bank[slot[IDX_W-1:0]] = push_bank;
            s_d.row[slot[IDX_W-1:0]]  = push_row;
            s_d.cnt                   = s_d.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ent_vld  = s_q.vld;
    assign ent_bank = s_q.bank;
    assign ent_row  = s_q.row;
    assign count    = s_q.cnt;
endmodule

// File: rtl/srq_pick.sv
// Per-bank choice inside one pool: latched row, else open row, else oldest.
module srq_pick #(
    parameter int DEPTH   = 8,
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 3,
    parameter int BANK_ID = 0,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0]             ent_vld,
    input  logic [DEPTH-1:0][BANK_W-1:0] ent_bank,
    input  logic [DEPTH-1:0][ROW_W-1:0]  ent_row,
    input  logic [ROW_W-1:0]             open_row,
    input  logic                         lat_vld,
    input  logic [ROW_W-1:0]             lat_row,
    output logic                         found,
    output logic [IDX_W-1:0]             idx,
    output logic [ROW_W-1:0]             row,
    output logic                         hit,
    output logic                         last
);
    localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

    logic [ROW_W-1:0] want;
    logic             pref_ok, old_ok;
    logic [IDX_W-1:0] pref_idx, old_idx;
    logic [CNT_W-1:0] same_cnt;

    always_comb begin
        want     = lat_vld ? lat_row : open_row;
        pref_ok  = 1'b0;
        old_ok   = 1'b0;
        pref_idx = '0;
        old_idx  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_vld[i] && ent_bank[i] == MY_BANK) begin
                if (!old_ok) begin
                    old_ok  = 1'b1;
                    old_idx = IDX_W'(i);
                end
                if (!pref_ok && ent_row[i] == want) begin
                    pref_ok  = 1'b1;
                    pref_idx = IDX_W'(i);
                end
            end
        end
        found = lat_vld ? pref_ok : (pref_ok || old_ok);
        idx   = pref_ok ? pref_idx : old_idx;
        hit   = pref_ok;
        row   = ent_row[idx];
        same_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_vld[i] && ent_bank[i] == MY_BANK && ent_row[i] == row)
                same_cnt = same_cnt + CNT_W'(1);
        end
        last = (same_cnt == CNT_W'(1));
    end
endmodule

// File: rtl/srq_sched.sv
module srq_sched
    import srq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 3,
    parameter int RD_DEPTH  = 8,
    parameter int WR_DEPTH  = 8,
    parameter int WR_HI     = 6,
    parameter int WR_LO     = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int RD_CW    = $clog2(RD_DEPTH + 1),
    localparam int WR_CW    = $clog2(WR_DEPTH + 1),
    localparam int RD_IW    = $clog2(RD_DEPTH),
    localparam int WR_IW    = $clog2(WR_DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [BANK_W-1:0]            req_bank,
    input  logic [ROW_W-1:0]             req_row,
    input  logic [NUM_BANKS-1:0]         bank_busy,
    input  logic [NUM_BANKS*ROW_W-1:0]   bank_open_row,
    output logic [NUM_BANKS-1:0]         disp_valid,
    output logic [ROW_W-1:0]             disp_row,
    output logic                         disp_write,
    output logic                         disp_hit
);
    localparam logic [WR_CW-1:0]  HI_C   = WR_CW'(WR_HI);
    localparam logic [WR_CW-1:0]  LO_C   = WR_CW'(WR_LO);
    localparam logic [RD_CW-1:0]  RD_CAP = RD_CW'(RD_DEPTH);
    localparam logic [WR_CW-1:0]  WR_CAP = WR_CW'(WR_DEPTH);
    localparam logic [BANK_W-1:0] TOP_B  = BANK_W'(NUM_BANKS - 1);

    typedef struct packed {
        srq_mode_e                          mode;
        logic [BANK_W-1:0]                  prio;
        logic [NUM_BANKS-1:0]               rd_lv;
        logic [NUM_BANKS-1:0][ROW_W-1:0]    rd_lr;
        logic [NUM_BANKS-1:0]               wr_lv;
        logic [NUM_BANKS-1:0][ROW_W-1:0]    wr_lr;
    } sched_t;

    sched_t s_d, s_q;

    // pool storage
    logic                              rd_push, wr_push, rd_pop, wr_pop;
    logic [RD_IW-1:0]                  rd_pop_idx;
    logic [WR_IW-1:0]                  wr_pop_idx;
    logic [RD_DEPTH-1:0]               rd_vld;
    logic [RD_DEPTH-1:0][BANK_W-1:0]   rd_bank;
    logic [RD_DEPTH-1:0][ROW_W-1:0]    rd_row;
    logic [WR_DEPTH-1:0]               wr_vld;
    logic [WR_DEPTH-1:0][BANK_W-1:0]   wr_bank;
    logic [WR_DEPTH-1:0][ROW_W-1:0]    wr_row;
    logic [RD_CW-1:0]                  rd_cnt;
    logic [WR_CW-1:0]                  wr_cnt;

    srq_pool #(.DEPTH(RD_DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_rd_pool (
        .clk(clk), .rst_n(rst_n),
        .push(rd_push), .push_bank(req_bank), .push_row(req_row),
        .pop(rd_pop), .pop_idx(rd_pop_idx),
        .ent_vld(rd_vld), .ent_bank(rd_bank), .ent_row(rd_row), .count(rd_cnt)
    );

    srq_pool #(.DEPTH(WR_DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_wr_pool (
        .clk(clk), .rst_n(rst_n),
        .push(wr_push), .push_bank(req_bank), .push_row(req_row),
        .pop(wr_pop), .pop_idx(wr_pop_idx),
        .ent_vld(wr_vld), .ent_bank(wr_bank), .ent_row(wr_row), .count(wr_cnt)
    );

    // per-bank candidates in each pool
    logic             rd_ok   [NUM_BANKS];
    logic [RD_IW-1:0] rd_idx  [NUM_BANKS];
    logic [ROW_W-1:0] rd_prow [NUM_BANKS];
    logic             rd_hit  [NUM_BANKS];
    logic             rd_last [NUM_BANKS];
    logic             wr_ok   [NUM_BANKS];
    logic [WR_IW-1:0] wr_idx  [NUM_BANKS];
    logic [ROW_W-1:0] wr_prow [NUM_BANKS];
    logic             wr_hit  [NUM_BANKS];
    logic             wr_last [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        srq_pick #(.DEPTH(RD_DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .BANK_ID(g)) u_rd_pick (
            .ent_vld(rd_vld), .ent_bank(rd_bank), .ent_row(rd_row),
            .open_row(bank_open_row[g*ROW_W +: ROW_W]),
            .lat_vld(s_q.rd_lv[g]), .lat_row(s_q.rd_lr[g]),
            .found(rd_ok[g]), .idx(rd_idx[g]), .row(rd_prow[g]),
            .hit(rd_hit[g]), .last(rd_last[g])
        );
        srq_pick #(.DEPTH(WR_DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .BANK_ID(g)) u_wr_pick (
            .ent_vld(wr_vld), .ent_bank(wr_bank), .ent_row(wr_row),
            .open_row(bank_open_row[g*ROW_W +: ROW_W]),
            .lat_vld(s_q.wr_lv[g]), .lat_row(s_q.wr_lr[g]),
            .found(wr_ok[g]), .idx(wr_idx[g]), .row(wr_prow[g]),
            .hit(wr_hit[g]), .last(wr_last[g])
        );
    end

    always_comb begin
        srq_mode_e         eff;
        logic              sel_ok;
        logic [BANK_W-1:0] sel, b;

        s_d = s_q;

        // mode decided from the write count held at the start of the cycle
        eff = s_q.mode;
        if (s_q.mode == MODE_RD && wr_cnt >= HI_C)      eff = MODE_WR;
        else if (s_q.mode == MODE_WR && wr_cnt < LO_C)  eff = MODE_RD;
        s_d.mode = eff;

        // rotating scan over free banks
        sel_ok = 1'b0;
        sel    = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            b = BANK_W'((int'(s_q.prio) + k) % NUM_BANKS);
            if (!sel_ok && !bank_busy[b] &&
                ((eff == MODE_WR) ? wr_ok[b] : rd_ok[b])) begin
                sel_ok = 1'b1;
                sel    = b;
            end
        end

        disp_valid = '0;
        if (sel_ok) disp_valid[sel] = 1'b1;
        disp_write = (eff == MODE_WR);
        disp_row   = (eff == MODE_WR) ? wr_prow[sel] : rd_prow[sel];
        disp_hit   = (eff == MODE_WR) ? wr_hit[sel]  : rd_hit[sel];

        rd_pop     = sel_ok && (eff == MODE_RD);
        wr_pop     = sel_ok && (eff == MODE_WR);
        rd_pop_idx = rd_idx[sel];
        wr_pop_idx = wr_idx[sel];

        if (rd_pop) begin
            s_d.rd_lv[sel] = !rd_last[sel];
            s_d.rd_lr[sel] = rd_prow[sel];
        end
        if (wr_pop) begin
            s_d.wr_lv[sel] = !wr_last[sel];
            s_d.wr_lr[sel] = wr_prow[sel];
        end
        if (sel_ok) s_d.prio = (s_q.prio == TOP_B) ? '0 : s_q.prio + BANK_W'(1);

        // intake: room judged on the counts at the start of the cycle
        req_ready = req_write ? (wr_cnt != WR_CAP) : (rd_cnt != RD_CAP);
        rd_push   = req_valid && req_ready && !req_write;
        wr_push   = req_valid && req_ready && req_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/srq_sched_chk.sv
module srq_sched_chk #(
    parameter int NUM_BANKS = 4,
    parameter int WR_DEPTH  = 8,
    parameter int WR_HI     = 6,
    parameter int WR_LO     = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int WR_CW    = $clog2(WR_DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic                 req_ready,
    input logic [NUM_BANKS-1:0] bank_busy,
    input logic [NUM_BANKS-1:0] disp_valid,
    input logic                 disp_write,
    input logic                 mode,
    input logic [BANK_W-1:0]    prio,
    input logic [WR_CW-1:0]     wr_cnt
);
    localparam logic [WR_CW-1:0]  HI_C  = WR_CW'(WR_HI);
    localparam logic [WR_CW-1:0]  LO_C  = WR_CW'(WR_LO);
    localparam logic [WR_CW-1:0]  CAP_C = WR_CW'(WR_DEPTH);
    localparam logic [BANK_W-1:0] TOP_B = BANK_W'(NUM_BANKS - 1);

    logic              any_disp, wr_in, wr_out;
    logic [BANK_W-1:0] prio_nx;
    assign any_disp = |disp_valid;
    assign wr_in    = req_valid && req_ready && req_write;
    assign wr_out   = any_disp && disp_write;
    assign prio_nx  = (prio == TOP_B) ? '0 : prio + BANK_W'(1);

    a_r7_single_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(disp_valid));
    a_r7_free_bank_only: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid & bank_busy) == '0);
    a_r2_full_write_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (req_write && wr_cnt == CAP_C) |-> !req_ready);
    a_r8_prio_step: assert property (@(posedge clk) disable iff (!rst_n)
        any_disp |=> prio == $past(prio_nx));
    a_r8_prio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !any_disp |=> $stable(prio));
    a_r6_enter_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && wr_cnt >= HI_C) |=> mode);
    a_r6_leave_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && wr_cnt < LO_C) |=> !mode);
    a_r6_read_pool_only: assert property (@(posedge clk) disable iff (!rst_n)
        (any_disp && !mode && wr_cnt < HI_C) |-> !disp_write);
    a_r9_write_count: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> int'(wr_cnt) == int'($past(wr_cnt)) + int'($past(wr_in)) - int'($past(wr_out)));
endmodule

bind srq_sched srq_sched_chk #(
    .NUM_BANKS(NUM_BANKS), .WR_DEPTH(WR_DEPTH), .WR_HI(WR_HI), .WR_LO(WR_LO)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
    .bank_busy(bank_busy), .disp_valid(disp_valid), .disp_write(disp_write),
    .mode(s_q.mode), .prio(s_q.prio), .wr_cnt(wr_cnt)
);

// File: tb/sim_srq_sched.sv
module sim_srq_sched;
    localparam int NB = 4, RW = 3, RDD = 8, WRD = 8, HI = 6, LO = 3;
    localparam int BW = $clog2(NB);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic              req_ready;
    logic [BW-1:0]     req_bank = '0;
    logic [RW-1:0]     req_row = '0;
    logic [NB-1:0]     bank_busy = '1;
    logic [NB*RW-1:0]  bank_open_row = '0;
    logic [NB-1:0]     disp_valid;
    logic [RW-1:0]     disp_row;
    logic              disp_write, disp_hit;

    always #5 clk = ~clk;

    srq_sched #(.NUM_BANKS(NB), .ROW_W(RW), .RD_DEPTH(RDD), .WR_DEPTH(WRD),
                .WR_HI(HI), .WR_LO(LO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .bank_busy(bank_busy), .bank_open_row(bank_open_row),
        .disp_valid(disp_valid), .disp_row(disp_row),
        .disp_write(disp_write), .disp_hit(disp_hit)
    );

    int n_cmp = 0, n_bad = 0;

    // reference state, pool 0 = reads, pool 1 = writes, index 0 oldest
    int pb [2][16];
    int pr [2][16];
    int pn [2];
    int lv [2][NB];
    int lr [2][NB];
    int open_r [NB];
    int prio = 0, mode = 0;

    function automatic void check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endfunction

    function automatic void mpick(int p, int b, output int ok, output int idx,
                                  output int row, output int hit, output int last);
        int want, n;
        ok = 0; idx = 0; row = 0; hit = 0; last = 0;
        want = (lv[p][b] != 0) ? lr[p][b] : open_r[b];
        for (int i = 0; i < pn[p]; i++)
            if (ok == 0 && pb[p][i] == b && pr[p][i] == want) begin ok = 1; idx = i; hit = 1; end
        if (ok == 0 && lv[p][b] == 0)
            for (int i = 0; i < pn[p]; i++)
                if (ok == 0 && pb[p][i] == b) begin ok = 1; idx = i; end
        if (ok != 0) begin
            row = pr[p][idx];
            n = 0;
            for (int i = 0; i < pn[p]; i++)
                if (pb[p][i] == b && pr[p][i] == row) n++;
            last = (n == 1) ? 1 : 0;
        end
    endfunction

    task automatic step(input bit v, input bit w, input int bk, input int rw,
                        input logic [NB-1:0] busy);
        int eff, exp_rdy, sel, ok, idx, row, hit, last, s_idx, s_row, s_hit, s_last, p;
        @(negedge clk);
        req_valid = v; req_write = w;
        req_bank = BW'(bk); req_row = RW'(rw);
        bank_busy = busy;
        for (int b = 0; b < NB; b++) bank_open_row[b*RW +: RW] = RW'(open_r[b]);
        #1;
        eff = mode;
        if (mode == 0 && pn[1] >= HI) eff = 1;
        else if (mode == 1 && pn[1] < LO) eff = 0;
        p = w ? 1 : 0;
        exp_rdy = (pn[p] < (w ? WRD : RDD)) ? 1 : 0;
        check("R2 R9 req_ready", int'(req_ready), exp_rdy);
        sel = -1; s_idx = 0; s_row = 0; s_hit = 0; s_last = 0;
        for (int k = 0; k < NB; k++) begin
            int b;
            b = (prio + k) % NB;
            if (sel < 0 && !busy[b]) begin
                mpick(eff, b, ok, idx, row, hit, last);
                if (ok != 0) begin sel = b; s_idx = idx; s_row = row; s_hit = hit; s_last = last; end
            end
        end
        check("R7 R8 disp_valid", int'(disp_valid), (sel >= 0) ? (1 << sel) : 0);
        if (sel >= 0) begin
            check("R6 disp_write", int'(disp_write), eff);
            check("R3 R4 R5 disp_row", int'(disp_row), s_row);
            check("R3 R4 R5 disp_hit", int'(disp_hit), s_hit);
            for (int i = s_idx; i < pn[eff] - 1; i++) begin
                pb[eff][i] = pb[eff][i+1];
                pr[eff][i] = pr[eff][i+1];
            end
            pn[eff]--;
            lv[eff][sel] = s_last ? 0 : 1;
            lr[eff][sel] = s_row;
            prio = (prio + 1) % NB;
            open_r[sel] = s_row;
        end
        if (v && exp_rdy != 0) begin
            pb[p][pn[p]] = bk;
            pr[p][pn[p]] = rw;
            pn[p]++;
        end
        mode = eff;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog: actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            pn[p] = 0;
            for (int b = 0; b < NB; b++) begin lv[p][b] = 0; lr[p][b] = 0; end
        end
        for (int b = 0; b < NB; b++) open_r[b] = 0;

        // R1: reset state, all banks free
        bank_busy = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 disp_valid in reset", int'(disp_valid), 0);
        check("R1 req_ready in reset", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 disp_valid after reset", int'(disp_valid), 0);

        // R3 R4 R5: bank 1 with an older row-2 request and a younger open-row-5 one
        open_r[1] = 5;
        step(1, 0, 1, 2, '1);
        step(1, 0, 1, 5, '1);
        step(1, 0, 1, 2, '1);
        step(1, 0, 1, 3, '1);
        open_r[1] = 7;
        step(1, 0, 1, 2, '1);
        repeat (6) step(0, 0, 0, 0, 4'b1101);

        // R8: rotation with requests on banks 0 and 3
        step(1, 0, 0, 1, '1);
        step(1, 0, 0, 4, '1);
        step(1, 0, 3, 1, '1);
        step(1, 0, 3, 6, '1);
        repeat (6) step(0, 0, 0, 0, '0);

        // R2: all banks busy, fill both pools past capacity
        for (int i = 0; i < 40; i++)
            step(1, i[0], i % NB, (i * 3) % 8, '1);

        // R6 R9: mixed traffic with random busy slots and occasional row changes
        for (int i = 0; i < 3000; i++) begin
            logic [NB-1:0] bz;
            for (int b = 0; b < NB; b++) bz[b] = ($urandom_range(0, 9) < 3);
            if ($urandom_range(0, 19) == 0) open_r[$urandom_range(0, NB-1)] = $urandom_range(0, 7);
            step($urandom_range(0, 9) < 7, $urandom_range(0, 1) == 1,
                 $urandom_range(0, NB-1), $urandom_range(0, 7), bz);
        end

        // drain with no new requests
        for (int i = 0; i < 200; i++) begin
            logic [NB-1:0] bz;
            for (int b = 0; b < NB; b++) bz[b] = ($urandom_range(0, 9) < 3);
            step(0, 0, 0, 0, bz);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule